// File: doc/BRIEF.md
# Four-Output PWM Generator Group

This block drives four pulse-width-modulated outputs from one shared period counter. The counter runs in one of two shapes. In edge-aligned mode it climbs and wraps. In center-aligned mode it climbs to the period value and falls back, so each pulse sits symmetrically around the count of zero. Each output compares the shared count against its own duty value.

In independent mode the four outputs follow four separate duty values. In paired mode the outputs form two pairs. The even output of each pair follows the pair's duty value and the odd output is its complement. A programmable dead time holds back every rising edge, so the two outputs of a pair are never high together. All settings are written through a small register port into shadow copies. They reach the live copies only at defined reload points: each period start, and also the top of the count in center-aligned double-update mode, which makes asymmetric pulses possible. A single-cycle flag marks every period start.

The counter is a three-state machine. IDLE holds the count at 0 and reloads every live setting on each cycle. UP counts upward. DOWN counts downward in center-aligned mode. The transitions are:
- start: IDLE→UP, when enable is sampled high.
- wrap: UP→UP, in edge-aligned mode when the count reaches PERIOD−1.
- turn: UP→DOWN, in center-aligned mode when the count reaches PERIOD−1; the next count is PERIOD.
- return: DOWN→UP, when the count reaches 1; the next count is 0.
- stop: UP or DOWN→IDLE, when enable is sampled low.

Top module: `pwm_group`

## Requirements
- R1: While enable is low the counter stays in IDLE. Two cycles after enable is sampled low, all four outputs are low and the period flag is low.
- R2: In edge-aligned mode (config bit 0 = 0) the count runs 0,1,…,PERIOD−1 and then wraps to 0. The period flag is high exactly in the cycles where the count is 0, which is once every PERIOD cycles.
- R3: In center-aligned mode (config bit 0 = 1) the count runs 0 up to PERIOD, then back down to 1, giving a period of 2·PERIOD cycles. The flag is high once per period, when the count is 0.
- R4: A channel's compare result is high while the count is below its live duty value D, or whenever D ≥ PERIOD. D = 0 keeps the output low. Outputs are registered one cycle after the count. Over one period, a channel is high for D cycles in edge-aligned mode and for 2·D−1 cycles in center-aligned mode (1 ≤ D < PERIOD).
- R5: In independent mode (config bit 1 = 0), output i follows duty register i (register address i+1) with no dead time.
- R6: In paired mode (config bit 1 = 1), outputs 0 and 2 follow duty registers 0 and 2, and outputs 1 and 3 are their complements. Duty registers 1 and 3 have no effect.
- R7: In paired mode every rising edge of an output comes DEAD+1 cycles after its compare result rises, where DEAD is register address 6. Falling edges come after one cycle. The two outputs of a pair are never high together.
- R8: Writes to period (address 0), duty, config (address 5) and dead time land in shadow registers. They become live at the next period start, or on the next cycle while disabled. Period values below 2 act as 2.
- R9: In center-aligned single-update mode (config bit 2 = 0) duty values reload only at the period start.
- R10: In center-aligned double-update mode (config bit 2 = 1) duty values also reload at the top of the count, so the falling half of a period can use a new duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the period counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 period, 1–4 duty 0–3, 5 config, 6 dead time |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | PWM outputs |
| period_flag | output | 1 | High in the cycle where a period starts (count 0) |

## Verification
Each scenario measures the number of high cycles on every output over one whole period, and the number of flag pulses over a fixed window. These totals do not depend on phase, so they separate the count shapes: D versus 2·D−1 high cycles for the edge-aligned and center-aligned shapes. Duty values of 0, mid-range, exactly PERIOD and above PERIOD exercise the forced-low and forced-high limits. Paired runs with a dead time of zero and a dead time of three show the complement mapping, the ignored odd duty registers and the shortened rising phases. Mid-period writes, with and without double update, show that old values hold until the correct reload point: 3 then 11 high cycles for single update, 7 then 11 for double update.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    // packed: center is bit 0, paired bit 1, dbl_upd bit 2
    typedef struct packed {
        logic dbl_upd;
        logic paired;
        logic center;
    } grp_cfg_t;

endpackage

// File: rtl/pwm_grp_counter.sv
module pwm_grp_counter
    import pwm_grp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          center,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] cnt,
    output cnt_state_e    state,
    output logic          start_ld,
    output logic          mid_ld
);

    cnt_state_e    state_d;
    logic [CW-1:0] cnt_d;
    logic          top_hit;

    assign top_hit = (cnt >= per - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state;
        cnt_d    = cnt;
        start_ld = 1'b0;
        mid_ld   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start_ld = 1'b1;
                cnt_d    = '0;
                if (run_en) state_d = ST_UP;
            end
            ST_UP: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (top_hit) begin
                    if (center) begin
                        state_d = ST_DOWN;
                        cnt_d   = per;
                        mid_ld  = 1'b1;
                    end else begin
                        cnt_d    = '0;
                        start_ld = 1'b1;
                    end
                end else begin
                    cnt_d = cnt + CW'(1);
                end
            end
            ST_DOWN: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt <= CW'(1)) begin
                    state_d  = ST_UP;
                    cnt_d    = '0;
                    start_ld = 1'b1;
                end else begin
                    cnt_d = cnt - CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> cnt == '0);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |-> cnt <= per);

    // R3
    turn_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN && $past(state) == ST_UP) |-> cnt == per);

endmodule

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
    import pwm_grp_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int DTW = 8,
    parameter int AW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [CW-1:0]           wr_data,
    input  logic                    start_ld,
    input  logic                    mid_ld,
    output logic [CW-1:0]           per_act,
    output logic [NCH-1:0][CW-1:0]  duty_act,
    output grp_cfg_t                cfg_act,
    output logic [DTW-1:0]          dead_act
);

    localparam int ADR_PER  = 0;
    localparam int ADR_CFG  = NCH + 1;
    localparam int ADR_DEAD = NCH + 2;
    localparam int MIN_PER  = 2;

    logic [CW-1:0]          per_sh,  per_q;
    logic [NCH-1:0][CW-1:0] duty_sh, duty_q;
    grp_cfg_t               cfg_sh,  cfg_q;
    logic [DTW-1:0]         dead_sh, dead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
            cfg_sh  <= '0;
            dead_sh <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADR_PER))  per_sh  <= wr_data;
            if (wr_addr == AW'(ADR_CFG))  cfg_sh  <= grp_cfg_t'(wr_data[2:0]);
            if (wr_addr == AW'(ADR_DEAD)) dead_sh <= wr_data[DTW-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(i + 1)) duty_sh[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
            cfg_q  <= '0;
            dead_q <= '0;
        end else if (start_ld) begin
            per_q  <= per_sh;
            duty_q <= duty_sh;
            cfg_q  <= cfg_sh;
            dead_q <= dead_sh;
        end else if (mid_ld && cfg_q.dbl_upd) begin
            duty_q <= duty_sh;
        end
    end

    assign per_act  = (per_q < CW'(MIN_PER)) ? CW'(MIN_PER) : per_q;
    assign duty_act = duty_q;
    assign cfg_act  = cfg_q;
    assign dead_act = dead_q;

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ld && !mid_ld) |=> $stable(duty_q));

    // R8
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ld |=> $stable(per_q) && $stable(cfg_q));

    // R9
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ld && !cfg_q.dbl_upd) |=> $stable(duty_q));

endmodule

// File: rtl/pwm_grp_deadtime.sv
module pwm_grp_deadtime #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_raw,
    input  logic [DTW-1:0] dead,
    output logic           out_q
);

    logic [DTW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            wait_cnt <= '0;
        end else if (!in_raw) begin
            out_q    <= 1'b0;
            wait_cnt <= '0;
        end else if (wait_cnt >= dead) begin
            out_q <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + DTW'(1);
        end
    end

    // R7
    rise_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $past(in_raw));

    // R7
    fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_raw |=> !out_q);

endmodule

// File: rtl/pwm_group.sv
module pwm_group
    import pwm_grp_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int DTW = 8,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out,
    output logic           period_flag
);

    localparam int NPAIR = NCH / 2;

    logic [CW-1:0]          cnt;
    cnt_state_e             state;
    logic                   start_ld, mid_ld, running;
    logic [CW-1:0]          per_act;
    logic [NCH-1:0][CW-1:0] duty_act;
    grp_cfg_t               cfg_act;
    logic [DTW-1:0]         dead_act;
    logic [NCH-1:0]         raw;

    pwm_grp_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (enable),
        .center   (cfg_act.center),
        .per      (per_act),
        .cnt      (cnt),
        .state    (state),
        .start_ld (start_ld),
        .mid_ld   (mid_ld)
    );

    pwm_grp_regs #(.CW(CW), .NCH(NCH), .DTW(DTW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .start_ld (start_ld),
        .mid_ld   (mid_ld),
        .per_act  (per_act),
        .duty_act (duty_act),
        .cfg_act  (cfg_act),
        .dead_act (dead_act)
    );

    assign running     = (state != ST_IDLE);
    assign period_flag = running && (cnt == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int SRC = (i / 2) * 2;
        logic [CW-1:0]  d_sel;
        logic           hit;
        logic [DTW-1:0] dead_sel;

        assign d_sel    = cfg_act.paired ? duty_act[SRC] : duty_act[i];
        assign hit      = (d_sel >= per_act) || (cnt < d_sel);
        assign dead_sel = cfg_act.paired ? dead_act : '0;

        if (i % 2 == 1) begin : g_odd
            assign raw[i] = running && (cfg_act.paired ? !hit : hit);
        end else begin : g_even
            assign raw[i] = running && hit;
        end

        pwm_grp_deadtime #(.DTW(DTW)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_raw (raw[i]),
            .dead   (dead_sel),
            .out_q  (pwm_out[i])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        // R7
        pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_act.paired && $past(cfg_act.paired))
                |-> !(pwm_out[2*p] && pwm_out[2*p+1]));
    end

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(enable, 2)) |-> (pwm_out == '0 && !period_flag));

    // R2
    flag_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_flag |=> !period_flag);

endmodule

// File: tb/pwm_group_tb.sv
`timescale 1ns/1ps
module pwm_group_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_out;
    logic        period_flag;

    int checks = 0;
    int fails = 0;
    int hi[4];
    int flags = 0;
    int ovl = 0;
    bit cnt_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_group u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_out     (pwm_out),
        .period_flag (period_flag)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (cnt_en) begin
            for (int i = 0; i < 4; i++) hi[i] += int'(pwm_out[i]);
            flags += int'(period_flag);
            if ((pwm_out[0] && pwm_out[1]) || (pwm_out[2] && pwm_out[3])) ovl++;
        end
    endtask

    task automatic window(int n);
        for (int i = 0; i < 4; i++) hi[i] = 0;
        flags = 0;
        ovl = 0;
        cnt_en = 1'b1;
        repeat (n) tick();
        cnt_en = 1'b0;
    endtask

    task automatic write_reg(int a, int d);
        wr_en = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        tick();
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (period_flag) break;
        end
    endtask

    task automatic setup(int cfg, int per, int d0, int d1, int d2, int d3, int dead);
        enable = 1'b0;
        repeat (3) tick();
        write_reg(5, cfg);
        write_reg(0, per);
        write_reg(1, d0);
        write_reg(2, d1);
        write_reg(3, d2);
        write_reg(4, d3);
        write_reg(6, dead);
        repeat (2) tick();
        enable = 1'b1;
        wait_flag();
    endtask

    task automatic t_reset();
        check("R1 reset outputs", int'(pwm_out), 0);
        check("R1 reset flag", int'(period_flag), 0);
    endtask

    task automatic t_edge();
        setup(0, 10, 0, 3, 10, 12, 0);
        window(10);
        check("R4 duty 0 low", hi[0], 0);
        check("R5 edge duty 3", hi[1], 3);
        check("R4 duty = period high", hi[2], 10);
        check("R4 duty > period high", hi[3], 10);
        window(40);
        check("R2 edge flag count", flags, 4);
    endtask

    task automatic t_center();
        setup(1, 8, 3, 0, 8, 1, 0);
        window(16);
        check("R3 center duty 3", hi[0], 5);
        check("R3 center duty 0", hi[1], 0);
        check("R3 center duty = period", hi[2], 16);
        check("R3 center duty 1", hi[3], 1);
        window(32);
        check("R3 center flag count", flags, 2);
    endtask

    task automatic t_paired();
        setup(2, 20, 8, 5, 20, 0, 0);
        window(20);
        window(20);
        check("R6 pair0 even", hi[0], 8);
        check("R6 pair0 odd ignores duty1", hi[1], 12);
        check("R6 pair1 even", hi[2], 20);
        check("R6 pair1 odd", hi[3], 0);
        setup(2, 20, 8, 5, 20, 0, 3);
        window(20);
        window(20);
        check("R7 dead even", hi[0], 5);
        check("R7 dead odd", hi[1], 9);
        check("R7 dead steady high", hi[2], 20);
        check("R7 no overlap", ovl, 0);
    endtask

    task automatic t_shadow();
        setup(0, 10, 3, 0, 0, 0, 0);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd7;
        window(10);
        check("R8 old duty holds", hi[0], 3);
        window(10);
        check("R8 new duty at start", hi[0], 7);
        wait_flag();
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd5;
        window(20);
        check("R8 period reload", flags, 3);
    endtask

    task automatic t_update(bit dbl);
        setup(dbl ? 5 : 1, 8, 2, 0, 0, 0, 0);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd6;
        window(16);
        if (dbl) check("R10 mid reload", hi[0], 7);
        else     check("R9 no mid reload", hi[0], 3);
        window(16);
        if (dbl) check("R10 next period", hi[0], 11);
        else     check("R9 next period", hi[0], 11);
    endtask

    task automatic t_disable();
        setup(0, 10, 5, 5, 5, 5, 0);
        enable = 1'b0;
        repeat (2) tick();
        window(10);
        check("R1 disabled out0", hi[0], 0);
        check("R1 disabled out3", hi[3], 0);
        check("R1 disabled flag", flags, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) hi[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_edge();
        t_center();
        t_paired();
        t_shadow();
        t_update(1'b0);
        t_update(1'b1);
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule